// File: doc/BRIEF.md
# Duplex Grid Scanner With PWM Dimming

This block drives a two-grid multiplexed display. It runs on the system clock. A phase counter advances once per oscillator half period, and each advance arrives as a one-cycle pulse on `osc_tick_i`. One frame is 4096 ticks, which is 2048 oscillator periods. The first 2048 ticks are the slot for grid 1 and the next 2048 ticks are the slot for grid 2. During its slot, a grid output is pulled low for an on window that starts at the beginning of the slot. While that grid is low, the segment outputs carry the matching 32-bit half of the latched 64-bit segment word.

The length of the on window comes from a 10-bit dimming code. Each code step adds one oscillator period, which is two ticks. The top of the code range saturates at 2031 ticks, so the maximum on time is a little under half the frame. The block samples the dimming code only at slot boundaries, so a pulse that is already running is never cut short or stretched. A blank input forces the segments low. After reset the segments also stay dark until the first segment-load strobe arrives. The grids scan from reset onward with whatever dimming code is present.

Top module: `duplex_grid_scan`

## Requirements
- R1: The phase counter advances by one on each cycle where `osc_tick_i` is high. A frame is 4096 ticks. Grid 1 owns the first 2048 ticks of the frame and grid 2 owns the last 2048.
- R2: For a code c in the range 0x000 to 0x3F7, each grid is low for exactly 2*c ticks per frame. The window starts at the first tick of that grid's slot.
- R3: Codes 0x3F8 through 0x3FF all give an on window of 2031 ticks per grid per frame.
- R4: Code 0 never drives either grid low.
- R5: Grid outputs are active low. The two grids are never low in the same cycle, and a grid is high outside its on window.
- R6: While `grid1_no` is low, `seg_o` equals `seg_data_i[31:0]`. While `grid2_no` is low, `seg_o` equals `seg_data_i[63:32]`. While both grids are high, `seg_o` is zero.
- R7: When `blank_n_i` is low, `seg_o` is zero from the next cycle on. Blanking does not change the grid timing.
- R8: After reset, `seg_o` stays zero until the first cycle with `seg_load_i` high. From then on, segments are shown as in R6 until the next reset.
- R9: A new dimming code takes effect at the next slot boundary. A change in the middle of a slot leaves the length of the current pulse unchanged.
- R10: The counter holds when `osc_tick_i` is low. With a tick on every second cycle, every on time measured in clock cycles doubles.
- R11: During reset, both grids are high, `seg_o` is zero, and the counter sits at the start of the grid 1 slot. Until the first slot boundary the on window is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One pulse per oscillator half period |
| seg_data_i | input | 64 | Latched segment word; low half for grid 1, high half for grid 2 |
| dim_i | input | 10 | Latched dimming code |
| seg_load_i | input | 1 | Strobe marking a segment-data latch event |
| blank_n_i | input | 1 | Low forces segments dark |
| grid1_no | output | 1 | Grid 1 drive, active low |
| grid2_no | output | 1 | Grid 2 drive, active low |
| seg_o | output | 32 | Segment outputs |

## Verification
Two functions can act in the same cycle. A dimming-code change can land in the middle of a running grid pulse, and blanking can overlap an active grid window. The bench changes the code 50 cycles into a grid 1 pulse. It then checks that the pulse still ends at the old length and that the grid 2 pulse that follows uses the new length. It also holds `blank_n_i` low across a whole frame and checks two things: the grids still show their full on counts, and the segments never leave zero.

// File: rtl/dgs_pkg.sv
package dgs_pkg;
  typedef enum logic {SLOT_G1 = 1'b0, SLOT_G2 = 1'b1} slot_e;
endpackage

// File: rtl/dgs_phase_gen.sv
module dgs_phase_gen #(
  parameter int PHASE_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  output dgs_pkg::slot_e       slot_o,
  output logic [PHASE_W-2:0]   pos_o,
  output logic                 slot_end_o
);
  logic [PHASE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign slot_o     = dgs_pkg::slot_e'(cnt_q[PHASE_W-1]);
  assign pos_o      = cnt_q[PHASE_W-2:0];
  assign slot_end_o = tick_i && (&cnt_q[PHASE_W-2:0]);

  assert_hold_no_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/dgs_dim_window.sv
module dgs_dim_window #(
  parameter int DIM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIM_W-1:0] dim_i,
  input  logic             slot_end_i,
  output logic [DIM_W:0]   on_len_o
);
  localparam int LEN_W    = DIM_W + 1;
  localparam int SAT_CODE = (2 ** DIM_W) - 8;
  localparam int SAT_LEN  = 2 * SAT_CODE - 1;

  logic [LEN_W-1:0] len_d, len_q;

  // half-step top: the saturating range gets one tick less than 2*SAT_CODE
  always_comb begin
    if (dim_i >= DIM_W'(SAT_CODE)) len_d = LEN_W'(SAT_LEN);
    else                           len_d = {dim_i, 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         len_q <= '0;
    else if (slot_end_i) len_q <= len_d;
  end

  assign on_len_o = len_q;

  assert_len_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_end_i |=> $stable(len_q));
  assert_len_sat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end_i && dim_i >= DIM_W'(SAT_CODE)) |=> len_q == LEN_W'(SAT_LEN));
endmodule

// File: rtl/dgs_out_stage.sv
module dgs_out_stage #(
  parameter int SEG_W = 32,
  parameter int POS_W = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  dgs_pkg::slot_e       slot_i,
  input  logic [POS_W-1:0]     pos_i,
  input  logic [POS_W-1:0]     on_len_i,
  input  logic [2*SEG_W-1:0]   seg_data_i,
  input  logic                 seg_load_i,
  input  logic                 blank_n_i,
  output logic [1:0]           grid_n_o,
  output logic [SEG_W-1:0]     seg_o
);
  localparam int NGRID = 2;

  logic             on;
  logic [NGRID-1:0] win;
  logic [NGRID-1:0] grid_n_q;
  logic [SEG_W-1:0] seg_half, seg_d, seg_q;
  logic             shown_q;

  assign on     = pos_i < on_len_i;
  assign win[0] = on && (slot_i == dgs_pkg::SLOT_G1);
  assign win[1] = on && (slot_i == dgs_pkg::SLOT_G2);

  for (genvar g = 0; g < NGRID; g++) begin : g_grid
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) grid_n_q[g] <= 1'b1;
      else         grid_n_q[g] <= !win[g];
    end
  end

  assign seg_half = (slot_i == dgs_pkg::SLOT_G2) ? seg_data_i[2*SEG_W-1:SEG_W]
                                                 : seg_data_i[SEG_W-1:0];
  assign seg_d    = (on && blank_n_i && shown_q) ? seg_half : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q   <= '0;
      shown_q <= 1'b0;
    end else begin
      seg_q   <= seg_d;
      shown_q <= shown_q | seg_load_i;
    end
  end

  assign grid_n_o = grid_n_q;
  assign seg_o    = seg_q;

  assert_grid_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~grid_n_q) <= 1);
  assert_seg_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&grid_n_q) |-> seg_q == '0);
  assert_blank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_n_i |=> seg_q == '0);
  assert_dark_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shown_q |=> seg_q == '0);
  assert_shown_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shown_q |=> shown_q);
endmodule

// File: rtl/duplex_grid_scan.sv
module duplex_grid_scan #(
  parameter int SEG_W = 32,
  parameter int DIM_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               osc_tick_i,
  input  logic [2*SEG_W-1:0] seg_data_i,
  input  logic [DIM_W-1:0]   dim_i,
  input  logic               seg_load_i,
  input  logic               blank_n_i,
  output logic               grid1_no,
  output logic               grid2_no,
  output logic [SEG_W-1:0]   seg_o
);
  localparam int PHASE_W = DIM_W + 2;
  localparam int POS_W   = PHASE_W - 1;

  dgs_pkg::slot_e   slot;
  logic [POS_W-1:0] pos;
  logic             slot_end;
  logic [POS_W-1:0] on_len;
  logic [1:0]       grid_n;

  dgs_phase_gen #(.PHASE_W(PHASE_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (osc_tick_i),
    .slot_o     (slot),
    .pos_o      (pos),
    .slot_end_o (slot_end)
  );

  dgs_dim_window #(.DIM_W(DIM_W)) u_dim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dim_i      (dim_i),
    .slot_end_i (slot_end),
    .on_len_o   (on_len)
  );

  dgs_out_stage #(.SEG_W(SEG_W), .POS_W(POS_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_i     (slot),
    .pos_i      (pos),
    .on_len_i   (on_len),
    .seg_data_i (seg_data_i),
    .seg_load_i (seg_load_i),
    .blank_n_i  (blank_n_i),
    .grid_n_o   (grid_n),
    .seg_o      (seg_o)
  );

  assign grid1_no = grid_n[0];
  assign grid2_no = grid_n[1];
endmodule

// File: tb/duplex_grid_scan_bench.sv
`timescale 1ns/1ps
module duplex_grid_scan_bench;
  localparam int NVEC  = 8;
  localparam int FRAME = 4096;
  localparam logic [63:0] SEG_WORD = 64'hA5C3_0F96_1234_8001;

  // stimulus: code, tick divider; expected: grid low cycles per frame
  localparam logic [9:0] VEC_CODE [NVEC] = '{10'h000, 10'h001, 10'h155, 10'h3F7,
                                             10'h3F8, 10'h3FE, 10'h3FF, 10'h064};
  localparam int VEC_DIV  [NVEC] = '{1, 1, 1, 1, 1, 1, 1, 2};
  localparam int VEC_LOW  [NVEC] = '{0, 2, 682, 2030, 2031, 2031, 2031, 400};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic [63:0] seg_data = SEG_WORD;
  logic [9:0]  dim = '0;
  logic        seg_load = 1'b0;
  logic        blank_n = 1'b1;
  logic        grid1_n, grid2_n;
  logic [31:0] seg;
  int          tick_div = 1;
  int          errors = 0;
  int          checks = 0;

  always #5 clk = ~clk;

  duplex_grid_scan u_duplex_grid_scan (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .seg_data_i(seg_data),
    .dim_i(dim), .seg_load_i(seg_load), .blank_n_i(blank_n),
    .grid1_no(grid1_n), .grid2_no(grid2_n), .seg_o(seg)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (tick_div == 2) tick = ~tick;
    else               tick = 1'b1;
  endtask

  // one frame at the current divider; outputs sampled away from the edge
  task automatic run_frame(input bit expect_dark, output int lo1, output int lo2,
                           output int both, output int segbad);
    lo1 = 0; lo2 = 0; both = 0; segbad = 0;
    for (int i = 0; i < FRAME * tick_div; i++) begin
      step();
      if (!grid1_n) lo1++;
      if (!grid2_n) lo2++;
      if (!grid1_n && !grid2_n) both++;
      if (expect_dark || (grid1_n && grid2_n)) begin
        if (seg != '0) segbad++;
      end else if (!grid1_n) begin
        if (seg != SEG_WORD[31:0]) segbad++;
      end else if (seg != SEG_WORD[63:32]) segbad++;
    end
  endtask

  initial begin
    repeat (170000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all-R actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lo1, lo2, both, segbad, n;
    // R11 reset state
    repeat (3) @(negedge clk);
    check(grid1_n == 1'b1, "R11 grid1 high in reset", grid1_n, 1);
    check(grid2_n == 1'b1, "R11 grid2 high in reset", grid2_n, 1);
    check(seg == '0, "R11 seg zero in reset", seg, 0);
    rst_n = 1'b1;
    step();
    check(grid1_n && grid2_n, "R11 zero window before first boundary", {grid1_n, grid2_n}, 3);

    // R8 dark before first load, grids scan anyway
    dim = 10'd500;
    repeat (FRAME + 4) step();
    run_frame(1'b1, lo1, lo2, both, segbad);
    check(lo1 == 1000, "R8 grid1 scans before load", lo1, 1000);
    check(lo2 == 1000, "R8 grid2 scans before load", lo2, 1000);
    check(segbad == 0, "R8 seg dark before load", segbad, 0);
    seg_load = 1'b1; step(); seg_load = 1'b0;
    repeat (4) step();

    // table walk: R1 R2 R3 R4 R5 R6 R10
    for (int v = 0; v < NVEC; v++) begin
      dim = VEC_CODE[v];
      tick_div = VEC_DIV[v];
      repeat (FRAME * tick_div + 4) step();
      run_frame(1'b0, lo1, lo2, both, segbad);
      check(lo1 == VEC_LOW[v], $sformatf("R2/R3/R4/R10 grid1 low cycles code %0h", VEC_CODE[v]), lo1, VEC_LOW[v]);
      check(lo2 == VEC_LOW[v], $sformatf("R1/R2/R3 grid2 low cycles code %0h", VEC_CODE[v]), lo2, VEC_LOW[v]);
      check(both == 0, "R5 grids overlap", both, 0);
      check(segbad == 0, "R6 segment half mismatch", segbad, 0);
    end
    tick_div = 1;

    // R7 blank overlapping active windows
    dim = 10'd300;
    repeat (FRAME + 4) step();
    blank_n = 1'b0;
    repeat (4) step();
    run_frame(1'b1, lo1, lo2, both, segbad);
    check(segbad == 0, "R7 seg zero while blanked", segbad, 0);
    check(lo1 == 600 && lo2 == 600, "R7 grids unaffected by blank", lo1 + lo2, 1200);
    blank_n = 1'b1;

    // R9 dimming change in the middle of a pulse
    dim = 10'd100;
    repeat (FRAME + 4) step();
    while (!grid1_n) step();
    while (grid1_n) step();
    n = 0;
    while (!grid1_n) begin
      n++;
      if (n == 50) dim = 10'd10;
      step();
    end
    check(n == 200, "R9 running pulse keeps old length", n, 200);
    while (grid2_n) step();
    n = 0;
    while (!grid2_n) begin n++; step(); end
    check(n == 20, "R9 next slot uses new code", n, 20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule